// File: doc/BRIEF.md
# Latched-status interrupt aggregator

This block collects a word of level-sensitive interrupt sources into a single request line for a processor interrupt controller. Software sees two word-wide registers on a small word-addressed register bus: an enable register and a status register. When an enabled source is high, the set of active enabled sources is latched into status as one batch, and the request line goes high. Service code clears status bits by writing ones. When the last bit is cleared, the line either drops or, if sources arrived during service, goes on with the batch that was held back.

Sources that fire while the current batch is still in status, or while they are masked, are collected in an internal pending word. The enable register only ever gains bits. Once a write leaves the set of enabled sources unchanged, that write acts as a mask control instead. Bits that differ from the last written value are masked or unmasked, depending on whether the write turned any of them on.

The source word is registered once before use when `SRC_REG` is 1, which is the default. In a cycle that has both a register write and a source evaluation, the write is applied first and the evaluation sees the resulting status and pending words. The evaluation uses the enable and mask words as they stood before that cycle's write.

Top module: `intagg_top`

## Requirements
- R1: After reset, the enable register, status register, mask and pending word are all zero, and `irq_o` and `err_o` are low.
- R2: In each cycle in which some sampled source is high, a select word is formed as sampled sources AND enable word. An empty select word changes nothing.
- R3: A full write to word 0 (enable) ORs the data into the enable word, so bits are never cleared. The written value is stored and read back from word 0. A write that adds enable bits, or that writes zero while the enable word is zero, leaves the mask untouched.
- R4: When the select word overlaps neither the mask nor the current status, status is overwritten with the select word (not ORed) and `irq_o` goes high.
- R5: When the select word overlaps the current status, it is ORed into the pending word, and status and `irq_o` are unchanged.
- R6: A full enable write that leaves the enable word unchanged computes diff = stored value XOR data. If diff AND data is nonzero, the diff bits are cleared from the mask; otherwise they are set in the mask. A select word that overlaps the mask goes to pending.
- R7: A full nonzero write to word 1 (status) clears the bits written as one. If status is then zero, and the data was not all ones, one of two things happens. A nonzero pending word moves into status, pending is cleared and `irq_o` stays high. With nothing pending, `irq_o` goes low.
- R8: A full status write of zero changes nothing and raises `err_o` for exactly the one cycle that follows the write.
- R9: A full status write of all ones clears status and does nothing else: no replay and no change to `irq_o`.
- R10: Only writes with all byte strobes set take effect. Reads are combinational: word 0 returns the stored enable value, word 1 returns status, and any other word returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Level-sensitive interrupt sources |
| wr_i | input | 1 | Register write strobe |
| be_i | input | 4 | Byte enables of the write |
| addr_i | input | 2 | Word address for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Aggregated interrupt request |
| err_o | output | 1 | One-cycle pulse after a zero-data status write |

## Verification
Second arrivals are the main target. A source that fires on a bit still present in status must go to pending and must not be merged into status. A disjoint arrival must replace status outright, so a design that ORs, or that sends everything to pending, reads back the wrong batch. Service completion is checked both ways: a replay of the pending word that keeps the line high, and a final clear that drops it. An all-ones clear must keep the line high, so a design that treats it as service completion drops the line too early.

The remaining checks cover the enable register's two roles and the write rules. A mask-then-unmask pair catches swapped mask polarity. A bit-adding write must not disable earlier sources, which exposes a write-through enable. The bench also checks that a zero status write and a partial-strobe write are both ignored, and that the error pulse lasts exactly one cycle.

// File: rtl/intagg_pkg.sv
package intagg_pkg;
   localparam int unsigned EN_WORD = 0;
   localparam int unsigned ST_WORD = 1;

   typedef enum logic [1:0] {
      BUS_NONE = 2'd0,
      BUS_EN   = 2'd1,
      BUS_ST   = 2'd2
   } bus_tgt_e;
endpackage

// File: rtl/intagg_enable.sv
module intagg_enable #(
   parameter int unsigned N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [N-1:0] wdata_i,
   output logic [N-1:0] en_o,
   output logic [N-1:0] mask_o,
   output logic [N-1:0] stored_o
);
   logic [N-1:0] en_q, mask_q, stored_q;
   logic [N-1:0] en_d, mask_d, stored_d;
   logic [N-1:0] grown, diff;

   always_comb begin
      en_d     = en_q;
      mask_d   = mask_q;
      stored_d = stored_q;
      grown    = en_q | wdata_i;
      diff     = stored_q ^ wdata_i;
      if (wr_i) begin
         stored_d = wdata_i;
         if (wdata_i == '0 && en_q == '0) begin
            en_d = en_q;
         end else if (grown != en_q) begin
            en_d = grown;
         end else if ((diff & wdata_i) != '0) begin
            mask_d = mask_q & ~diff;
         end else begin
            mask_d = mask_q | diff;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q     <= '0;
         mask_q   <= '0;
         stored_q <= '0;
      end else begin
         en_q     <= en_d;
         mask_q   <= mask_d;
         stored_q <= stored_d;
      end
   end

   assign en_o     = en_q;
   assign mask_o   = mask_q;
   assign stored_o = stored_q;
endmodule

// File: rtl/intagg_status.sv
module intagg_status #(
   parameter int unsigned N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] src_i,
   input  logic [N-1:0] en_i,
   input  logic [N-1:0] mask_i,
   input  logic         wr_i,
   input  logic [N-1:0] wdata_i,
   output logic [N-1:0] status_o,
   output logic [N-1:0] pending_o,
   output logic         irq_o,
   output logic         err_o
);
   logic [N-1:0] st_q, pd_q, st_d, pd_d, pick;
   logic         irq_q, irq_d, err_q, err_d;

   always_comb begin
      st_d  = st_q;
      pd_d  = pd_q;
      irq_d = irq_q;
      err_d = 1'b0;
      if (wr_i) begin
         if (wdata_i == '0) begin
            err_d = 1'b1;
         end else begin
            st_d = st_d & ~wdata_i;
            if (wdata_i != '1 && st_d == '0) begin
               if (pd_d != '0) begin
                  st_d  = pd_d;
                  pd_d  = '0;
                  irq_d = 1'b1;
               end else begin
                  irq_d = 1'b0;
               end
            end
         end
      end
      pick = src_i & en_i;
      if (pick != '0) begin
         if ((pick & mask_i) != '0 || (pick & st_d) != '0) begin
            pd_d = pd_d | pick;
         end else begin
            st_d  = pick;
            irq_d = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= '0;
         pd_q  <= '0;
         irq_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         pd_q  <= pd_d;
         irq_q <= irq_d;
         err_q <= err_d;
      end
   end

   assign status_o  = st_q;
   assign pending_o = pd_q;
   assign irq_o     = irq_q;
   assign err_o     = err_q;
endmodule

// File: rtl/intagg_top.sv
module intagg_top
   import intagg_pkg::*;
#(
   parameter int unsigned N_SRC   = 32,
   parameter int unsigned ADDR_W  = 2,
   parameter bit          SRC_REG = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_SRC-1:0]    src_i,
   input  logic                wr_i,
   input  logic [N_SRC/8-1:0]  be_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [N_SRC-1:0]    wdata_i,
   output logic [N_SRC-1:0]    rdata_o,
   output logic                irq_o,
   output logic                err_o
);
   localparam int unsigned BE_W = N_SRC / 8;

   if (N_SRC % 8 != 0 || N_SRC < 8) begin : g_bad_width
      $error("N_SRC must be a nonzero multiple of 8");
   end
   if ((2 ** ADDR_W) <= ST_WORD) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end

   logic [N_SRC-1:0] src_s, en_w, mask_w, stored_w, status_w, pending_w;
   logic             full_wr;
   bus_tgt_e         tgt;

   if (SRC_REG) begin : g_src_reg
      logic [N_SRC-1:0] src_q;
      always_ff @(posedge clk) begin
         if (!rst_n) src_q <= '0;
         else        src_q <= src_i;
      end
      assign src_s = src_q;
   end else begin : g_src_direct
      assign src_s = src_i;
   end

   assign full_wr = wr_i && (be_i == {BE_W{1'b1}});

   always_comb begin
      tgt = BUS_NONE;
      if (full_wr && addr_i == ADDR_W'(EN_WORD)) tgt = BUS_EN;
      if (full_wr && addr_i == ADDR_W'(ST_WORD)) tgt = BUS_ST;
   end

   intagg_enable #(.N(N_SRC)) u_enable (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (tgt == BUS_EN),
      .wdata_i  (wdata_i),
      .en_o     (en_w),
      .mask_o   (mask_w),
      .stored_o (stored_w)
   );

   intagg_status #(.N(N_SRC)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src_s),
      .en_i      (en_w),
      .mask_i    (mask_w),
      .wr_i      (tgt == BUS_ST),
      .wdata_i   (wdata_i),
      .status_o  (status_w),
      .pending_o (pending_w),
      .irq_o     (irq_o),
      .err_o     (err_o)
   );

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_W'(EN_WORD)) rdata_o = stored_w;
      if (addr_i == ADDR_W'(ST_WORD)) rdata_o = status_w;
   end
endmodule

// File: rtl/intagg_chk.sv
module intagg_chk #(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned ADDR_W = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_i,
   input logic [N_SRC/8-1:0] be_i,
   input logic [ADDR_W-1:0]  addr_i,
   input logic [N_SRC-1:0]   wdata_i,
   input logic               irq_o,
   input logic               err_o,
   input logic [N_SRC-1:0]   en_w,
   input logic [N_SRC-1:0]   stored_w,
   input logic [N_SRC-1:0]   status_w
);
   logic full, zero_st_wr, ones_st_wr;
   assign full       = wr_i && (be_i == '1);
   assign zero_st_wr = full && addr_i == ADDR_W'(1) && wdata_i == '0;
   assign ones_st_wr = full && addr_i == ADDR_W'(1) && wdata_i == '1;

   assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(zero_st_wr));

   assert_rise_has_batch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> status_w != '0);

   assert_fall_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o) |-> status_w == '0);

   assert_partial_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && be_i != '1 && addr_i == ADDR_W'(0)) |=> $stable(stored_w));

   assert_enable_set_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_w & $past(en_w)) == $past(en_w));

   assert_init_keeps_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ones_st_wr |=> !$fell(irq_o));
endmodule

bind intagg_top intagg_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_i     (wr_i),
   .be_i     (be_i),
   .addr_i   (addr_i),
   .wdata_i  (wdata_i),
   .irq_o    (irq_o),
   .err_o    (err_o),
   .en_w     (en_w),
   .stored_w (stored_w),
   .status_w (status_w)
);

// File: tb/test_intagg_top.sv
`timescale 1ns/1ps
module test_intagg_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_i = '0;
   logic        wr_i = 1'b0;
   logic [3:0]  be_i = '0;
   logic [1:0]  addr_i = 2'd3;
   logic [31:0] wdata_i = '0;
   logic [31:0] rdata_o;
   logic        irq_o, err_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct {
      string       tag;
      int          kind;
      logic [31:0] exp;
   } item_t;
   item_t q[$];
   event  ev;

   always #10 clk = ~clk;

   intagg_top i_intagg_top (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_i(wr_i), .be_i(be_i),
      .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
      .irq_o(irq_o), .err_o(err_o)
   );

   initial begin
      forever begin
         @(ev);
         while (q.size() != 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
               0:       act = {31'b0, irq_o};
               1:       act = {31'b0, err_o};
               default: act = rdata_o;
            endcase
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic push(string tag, int kind, logic [31:0] exp);
      item_t it;
      it.tag = tag; it.kind = kind; it.exp = exp;
      q.push_back(it);
      ->ev;
      #1;
   endtask

   task automatic exp_irq(string tag, logic v);
      push(tag, 0, {31'b0, v});
   endtask

   task automatic exp_err(string tag, logic v);
      push(tag, 1, {31'b0, v});
   endtask

   task automatic exp_rd(string tag, logic [1:0] a, logic [31:0] v);
      addr_i = a;
      #1;
      push(tag, 2, v);
      addr_i = 2'd3;
   endtask

   task automatic bus_wr(logic [1:0] a, logic [31:0] d, logic [3:0] be);
      @(negedge clk);
      wr_i = 1'b1; addr_i = a; wdata_i = d; be_i = be;
      @(negedge clk);
      wr_i = 1'b0; addr_i = 2'd3; be_i = '0;
   endtask

   task automatic pulse(logic [31:0] v);
      @(negedge clk);
      src_i = v;
      @(negedge clk);
      src_i = '0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      exp_irq("R1 irq after reset", 1'b0);
      exp_err("R1 err after reset", 1'b0);
      exp_rd("R1 enable after reset", 2'd0, 32'h0);
      exp_rd("R1 status after reset", 2'd1, 32'h0);

      bus_wr(2'd0, 32'h0000_00FF, 4'hF);
      exp_rd("R3 enable readback", 2'd0, 32'h0000_00FF);

      pulse(32'h0000_0101);
      exp_rd("R2 select drops disabled source", 2'd1, 32'h0000_0001);
      exp_irq("R4 irq raised on delivery", 1'b1);

      pulse(32'h0000_0002);
      exp_rd("R4 disjoint arrival overwrites status", 2'd1, 32'h0000_0002);

      pulse(32'h0000_0002);
      exp_rd("R5 overlapping arrival leaves status", 2'd1, 32'h0000_0002);

      pulse(32'h0000_0004);
      exp_rd("R4 overwrite again", 2'd1, 32'h0000_0004);

      bus_wr(2'd1, 32'h0000_0004, 4'hF);
      exp_rd("R7 pending replayed into status", 2'd1, 32'h0000_0002);
      exp_irq("R7 irq held on replay", 1'b1);

      bus_wr(2'd1, 32'h0000_0002, 4'hF);
      exp_rd("R7 status cleared", 2'd1, 32'h0);
      exp_irq("R7 irq low when nothing pending", 1'b0);

      pulse(32'h0000_0008);
      exp_rd("R4 status loaded", 2'd1, 32'h0000_0008);
      bus_wr(2'd1, 32'h0, 4'hF);
      exp_err("R8 error pulse", 1'b1);
      exp_rd("R8 zero write ignored", 2'd1, 32'h0000_0008);
      @(negedge clk);
      exp_err("R8 error lasts one cycle", 1'b0);

      bus_wr(2'd1, 32'hFFFF_FFFF, 4'hF);
      exp_rd("R9 all ones clears status", 2'd1, 32'h0);
      exp_irq("R9 irq unchanged by init clear", 1'b1);

      bus_wr(2'd0, 32'h0000_000F, 4'hF);
      exp_rd("R6 mask write stored", 2'd0, 32'h0000_000F);
      pulse(32'h0000_0010);
      exp_rd("R6 masked source not in status", 2'd1, 32'h0);
      bus_wr(2'd1, 32'h0000_0001, 4'hF);
      exp_rd("R6 masked source was pending", 2'd1, 32'h0000_0010);
      bus_wr(2'd1, 32'h0000_0010, 4'hF);
      exp_irq("R7 irq low after service", 1'b0);

      bus_wr(2'd0, 32'h0000_00FF, 4'hF);
      pulse(32'h0000_0020);
      exp_rd("R6 unmasked source delivered", 2'd1, 32'h0000_0020);
      exp_irq("R6 irq after unmask", 1'b1);

      bus_wr(2'd0, 32'h0000_0100, 4'hF);
      exp_rd("R3 stored value is last write", 2'd0, 32'h0000_0100);
      pulse(32'h0000_0100);
      exp_rd("R3 new bit enabled", 2'd1, 32'h0000_0100);
      pulse(32'h0000_0001);
      exp_rd("R3 old bit still enabled", 2'd1, 32'h0000_0001);

      bus_wr(2'd1, 32'h0000_0001, 4'h1);
      exp_rd("R10 partial status write ignored", 2'd1, 32'h0000_0001);
      bus_wr(2'd0, 32'h0, 4'h3);
      exp_rd("R10 partial enable write ignored", 2'd0, 32'h0000_0100);
      exp_rd("R10 unmapped word reads zero", 2'd2, 32'h0);

      pulse(32'h8000_0000);
      exp_rd("R2 empty select no effect", 2'd1, 32'h0000_0001);

      #5;
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule